// File: doc/BRIEF.md
# Address Tenure Window Protocol Monitor

This block is a passive checker that sits beside a shared address bus. It watches two start strobes: a memory start strobe and an extended start strobe used for direct-store transfers. It also watches the address acknowledge and the address-busy level. From these four inputs it follows the forbidden window of the current address tenure. It judges every new strobe against that window and against the one-cycle pulse rule. All four inputs are active high, already synchronised, and sampled on the rising clock edge.

A legal memory start produces a one-cycle snoop-valid pulse, which tells a snooper that address and attributes may be captured. There are three classes of violation: early start, long strobe and extended strobe inside a memory tenure. Each class has its own one-cycle event output and its own sticky flag. All outputs are registered, so they appear in the cycle after the strobe cycle that caused them. The monitor drives no bus signal.

The window tracker is a four-state machine:
- `WIN_IDLE`: no tenure is open.
- `WIN_OPEN`: a tenure has started and waits for its acknowledge.
- `WIN_ACKTAIL`: the single cycle after the acknowledge, still forbidden.
- `WIN_BUSY`: the address-busy level outlived the acknowledge.

Transitions:
- `WIN_IDLE`→`WIN_OPEN`: on a legal start.
- `WIN_IDLE`→`WIN_ACKTAIL`: on a legal start that arrives together with an acknowledge.
- `WIN_OPEN`→`WIN_ACKTAIL`: on an acknowledge.
- `WIN_ACKTAIL`→`WIN_BUSY`: while busy is high.
- `WIN_ACKTAIL`→`WIN_IDLE`: while busy is low.
- `WIN_BUSY`→`WIN_IDLE`: on busy low.
- `WIN_BUSY`→`WIN_OPEN` or `WIN_ACKTAIL`: on a legal start in the first busy-low cycle.

Top module: `atw_monitor`

## Requirements
- R1: A fresh memory start strobe seen while no window is open gives `snoop_vld_o`=1 in the next cycle and no event.
- R2: The window opens in the cycle of a legal start and stays open until the acknowledge. A fresh strobe inside it raises `early_evt_o` in the next cycle, unless R6 applies.
- R3: The cycle after the acknowledge is still inside the window. If busy is low in that cycle, a strobe in the following cycle is legal.
- R4: If busy is still high in the cycle after the acknowledge, the window lasts through the last busy-high cycle. A strobe in the first busy-low cycle is legal.
- R5: A strobe that is high in two consecutive cycles raises `width_evt_o` only, in the cycle after the second. The window state is left unchanged.
- R6: A fresh extended strobe inside a window started by the memory strobe raises `xmem_evt_o`, not `early_evt_o`.
- R7: A fresh extended strobe outside a window opens a direct-store window without a snoop pulse. A fresh extended strobe inside that window is an early start.
- R8: Both strobes asserted fresh in the same cycle raise `early_evt_o`, give no snoop pulse and open no window.
- R9: Each sticky flag (`early_err_o`, `width_err_o`, `xmem_err_o`) rises together with its event. It then holds until `clr_i` or reset. When an event and `clr_i` fall in the same cycle, the event wins.
- R10: While `rst_n` is low at a clock edge, every output is 0 after that edge and the window closes.
- R11: An acknowledge in the same cycle as a legal start ends the window one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Clears the sticky flags |
| start_i | input | 1 | Memory start strobe, active high |
| xstart_i | input | 1 | Extended (direct-store) start strobe, active high |
| addr_ack_i | input | 1 | Address acknowledge, active high |
| addr_busy_i | input | 1 | Address bus busy level, active high |
| snoop_vld_o | output | 1 | One-cycle pulse after a legal memory start |
| early_evt_o | output | 1 | One-cycle early-start event |
| width_evt_o | output | 1 | One-cycle long-strobe event |
| xmem_evt_o | output | 1 | One-cycle event for an extended strobe in a memory tenure |
| early_err_o | output | 1 | Sticky early-start flag |
| width_err_o | output | 1 | Sticky long-strobe flag |
| xmem_err_o | output | 1 | Sticky extended-in-memory flag |

## Verification
The hardest state to reach from the ports is `WIN_BUSY`. To get there, busy must still be high in the cycle after the acknowledge, and the stimulus must then hit the exact first cycle in which busy drops. The bench holds busy across the acknowledge, strobes once while busy is still high and expects an early event. It then strobes in the first busy-low cycle and expects a clean snoop pulse. Separating a held strobe from a fresh one also needs care, because a held strobe must count as a width error and never as an early start. The stimulus therefore places each fresh strobe after an idle cycle, and places each held strobe directly after a legal start.

// File: rtl/atw_pkg.sv
package atw_pkg;
    typedef enum logic [1:0] {
        WIN_IDLE    = 2'd0,
        WIN_OPEN    = 2'd1,
        WIN_ACKTAIL = 2'd2,
        WIN_BUSY    = 2'd3
    } win_state_e;

    localparam int NUM_ERR   = 3;
    localparam int ERR_EARLY = 0;
    localparam int ERR_WIDTH = 1;
    localparam int ERR_XMEM  = 2;
endpackage

// File: rtl/atw_classify.sv
module atw_classify
    import atw_pkg::*;
(
    input  logic               start_i,
    input  logic               xstart_i,
    input  logic               start_q,
    input  logic               xstart_q,
    input  logic               win_closed,
    input  logic               mem_tenure,
    output logic               start_ok,
    output logic               start_mem,
    output logic [NUM_ERR-1:0] hit
);
    logic held;
    logic fresh;
    logic both;

    assign held      = (start_i & start_q) | (xstart_i & xstart_q);
    assign fresh     = (start_i | xstart_i) & ~held;
    assign both      = start_i & xstart_i;
    assign start_mem = start_i;

    always_comb begin
        hit      = '0;
        start_ok = 1'b0;
        if (held) begin
            hit[ERR_WIDTH] = 1'b1;
        end else if (fresh) begin
            if (both) begin
                hit[ERR_EARLY] = 1'b1;
            end else if (!win_closed) begin
                if (xstart_i && mem_tenure) begin
                    hit[ERR_XMEM] = 1'b1;
                end else begin
                    hit[ERR_EARLY] = 1'b1;
                end
            end else begin
                start_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/atw_window_fsm.sv
module atw_window_fsm
    import atw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       start_mem,
    input  logic       addr_ack_i,
    input  logic       addr_busy_i,
    output logic       win_closed,
    output logic       mem_tenure,
    output win_state_e state_q
);
    win_state_e state_d;
    logic       mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_IDLE;
            mem_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                mem_q <= start_mem;
            end
        end
    end

    always_comb begin
        state_d    = state_q;
        win_closed = 1'b0;
        unique case (state_q)
            WIN_IDLE: begin
                win_closed = 1'b1;
                if (start_ok) begin
                    state_d = addr_ack_i ? WIN_ACKTAIL : WIN_OPEN;
                end
            end
            WIN_OPEN: begin
                if (addr_ack_i) begin
                    state_d = WIN_ACKTAIL;
                end
            end
            WIN_ACKTAIL: begin
                state_d = addr_busy_i ? WIN_BUSY : WIN_IDLE;
            end
            WIN_BUSY: begin
                win_closed = !addr_busy_i;
                if (start_ok) begin
                    state_d = addr_ack_i ? WIN_ACKTAIL : WIN_OPEN;
                end else if (!addr_busy_i) begin
                    state_d = WIN_IDLE;
                end
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    assign mem_tenure = mem_q;
endmodule

// File: rtl/atw_err_bank.sv
module atw_err_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] hit,
    output logic [N-1:0] evt_q,
    output logic [N-1:0] flag_q
);
    for (genvar g = 0; g < N; g++) begin : g_cls
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt_q[g]  <= 1'b0;
                flag_q[g] <= 1'b0;
            end else begin
                evt_q[g]  <= hit[g];
                flag_q[g] <= hit[g] | (flag_q[g] & ~clr_i);
            end
        end
    end
endmodule

// File: rtl/atw_monitor.sv
module atw_monitor
    import atw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic start_i,
    input  logic xstart_i,
    input  logic addr_ack_i,
    input  logic addr_busy_i,
    output logic snoop_vld_o,
    output logic early_evt_o,
    output logic width_evt_o,
    output logic xmem_evt_o,
    output logic early_err_o,
    output logic width_err_o,
    output logic xmem_err_o
);
    logic               start_q;
    logic               xstart_q;
    logic               snoop_q;
    logic               start_ok;
    logic               start_mem;
    logic               win_closed;
    logic               mem_tenure;
    logic [NUM_ERR-1:0] hit;
    logic [NUM_ERR-1:0] evt;
    logic [NUM_ERR-1:0] flag;
    win_state_e         win_state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            xstart_q <= 1'b0;
            snoop_q  <= 1'b0;
        end else begin
            start_q  <= start_i;
            xstart_q <= xstart_i;
            snoop_q  <= start_ok & start_mem;
        end
    end

    atw_classify u_cls (
        .start_i    (start_i),
        .xstart_i   (xstart_i),
        .start_q    (start_q),
        .xstart_q   (xstart_q),
        .win_closed (win_closed),
        .mem_tenure (mem_tenure),
        .start_ok   (start_ok),
        .start_mem  (start_mem),
        .hit        (hit)
    );

    atw_window_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok    (start_ok),
        .start_mem   (start_mem),
        .addr_ack_i  (addr_ack_i),
        .addr_busy_i (addr_busy_i),
        .win_closed  (win_closed),
        .mem_tenure  (mem_tenure),
        .state_q     (win_state)
    );

    atw_err_bank #(.N(NUM_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .hit    (hit),
        .evt_q  (evt),
        .flag_q (flag)
    );

    assign snoop_vld_o = snoop_q;
    assign early_evt_o = evt[ERR_EARLY];
    assign width_evt_o = evt[ERR_WIDTH];
    assign xmem_evt_o  = evt[ERR_XMEM];
    assign early_err_o = flag[ERR_EARLY];
    assign width_err_o = flag[ERR_WIDTH];
    assign xmem_err_o  = flag[ERR_XMEM];
endmodule

// File: rtl/atw_monitor_chk.sv
module atw_monitor_chk
    import atw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic       start_i,
    input logic       xstart_i,
    input logic       snoop_vld_o,
    input logic       early_evt_o,
    input logic       width_evt_o,
    input logic       xmem_evt_o,
    input logic       early_err_o,
    input logic       width_err_o,
    input logic       xmem_err_o,
    input win_state_e win_state
);
    logic       seen;
    logic [2:0] evts;
    logic [2:0] errs;

    assign evts = {xmem_evt_o, width_evt_o, early_evt_o};
    assign errs = {xmem_err_o, width_err_o, early_err_o};

    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_snoop_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seen && snoop_vld_o |-> $past(start_i) && !$past(xstart_i));

    assert_open_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen && win_state == WIN_OPEN && start_i && !xstart_i && !$past(start_i)
        |=> early_evt_o && !snoop_vld_o);

    assert_held_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen && ((start_i && $past(start_i)) || (xstart_i && $past(xstart_i)))
        |=> width_evt_o && !early_evt_o && !xmem_evt_o);

    assert_both_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen && start_i && xstart_i && !$past(start_i) && !$past(xstart_i)
        |=> early_evt_o && !snoop_vld_o);

    assert_snoop_no_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_vld_o |-> evts == 3'b000);

    assert_evt_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evts & ~errs) == 3'b000);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (errs & $past(errs)) == $past(errs));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> !snoop_vld_o && evts == 3'b000 && errs == 3'b000);
endmodule

bind atw_monitor atw_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .start_i     (start_i),
    .xstart_i    (xstart_i),
    .snoop_vld_o (snoop_vld_o),
    .early_evt_o (early_evt_o),
    .width_evt_o (width_evt_o),
    .xmem_evt_o  (xmem_evt_o),
    .early_err_o (early_err_o),
    .width_err_o (width_err_o),
    .xmem_err_o  (xmem_err_o),
    .win_state   (u_fsm.state_q)
);

// File: tb/atw_monitor_tb_top.sv
module atw_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic       snoop;
        logic [2:0] evt;
        logic [2:0] flg;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic start_i = 1'b0;
    logic xstart_i = 1'b0;
    logic addr_ack_i = 1'b0;
    logic addr_busy_i = 1'b0;
    logic snoop_vld_o;
    logic early_evt_o, width_evt_o, xmem_evt_o;
    logic early_err_o, width_err_o, xmem_err_o;

    int   checks = 0;
    int   failures = 0;
    exp_t exp_q[$];
    logic [2:0] model_flg = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    atw_monitor dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .start_i     (start_i),
        .xstart_i    (xstart_i),
        .addr_ack_i  (addr_ack_i),
        .addr_busy_i (addr_busy_i),
        .snoop_vld_o (snoop_vld_o),
        .early_evt_o (early_evt_o),
        .width_evt_o (width_evt_o),
        .xmem_evt_o  (xmem_evt_o),
        .early_err_o (early_err_o),
        .width_err_o (width_err_o),
        .xmem_err_o  (xmem_err_o)
    );

    function automatic logic [6:0] actual_vec();
        return {snoop_vld_o, xmem_evt_o, width_evt_o, early_evt_o,
                xmem_err_o, width_err_o, early_err_o};
    endfunction

    // Monitor: pops one expected item per clock edge that followed a driven cycle.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [6:0] want;
            e = exp_q.pop_front();
            want = {e.snoop, e.evt, e.flg};
            checks++;
            if (actual_vec() !== want) begin
                failures++;
                $display("FAIL %s: got snoop/evt/flag=%b expected %b", e.req, actual_vec(), want);
            end
        end
    end

    // Driver: applies one cycle of stimulus at the falling edge and queues the outcome.
    // ev bit0 = early, bit1 = width, bit2 = extended-in-memory.
    task automatic cyc(input logic s, input logic x, input logic a, input logic b,
                       input logic c, input logic sn, input logic [2:0] ev, input string req);
        exp_t e;
        start_i = s; xstart_i = x; addr_ack_i = a; addr_busy_i = b; clr_i = c;
        model_flg = (model_flg & ~{3{c}}) | ev;
        e.snoop = sn; e.evt = ev; e.flg = model_flg; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (actual_vec() !== 7'b0) begin
            failures++;
            $display("FAIL %s: got %b expected %b", req, actual_vec(), 7'b0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset with strobes active leaves everything quiet
        start_i = 1'b1; xstart_i = 1'b1; addr_busy_i = 1'b1;
        repeat (3) @(negedge clk);
        check_quiet("R10 reset");
        start_i = 1'b0; xstart_i = 1'b0; addr_busy_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 legal start, R2/R3 window via acknowledge with busy low
        cyc(1,0,0,1,0, 1,3'b000, "R1 legal start");
        cyc(0,0,0,1,0, 0,3'b000, "R2 open idle");
        cyc(0,0,1,0,0, 0,3'b000, "R2 ack");
        cyc(1,0,0,0,0, 0,3'b001, "R3 strobe in ack tail");
        cyc(0,0,0,0,0, 0,3'b000, "R3 idle");
        cyc(1,0,0,1,0, 1,3'b000, "R3 legal after tail");
        // R4 busy outlasts acknowledge
        cyc(0,0,1,1,0, 0,3'b000, "R4 ack with busy");
        cyc(0,0,0,1,0, 0,3'b000, "R4 tail busy");
        cyc(1,0,0,1,0, 0,3'b001, "R4 strobe while busy");
        cyc(0,0,0,1,0, 0,3'b000, "R4 busy hold");
        cyc(1,0,0,0,0, 1,3'b000, "R4 first busy-low legal");
        // R5 held strobe
        cyc(1,0,0,1,0, 0,3'b010, "R5 held start");
        cyc(0,0,1,0,0, 0,3'b000, "R5 ack");
        cyc(0,0,0,0,0, 0,3'b000, "R5 tail");
        // R6 extended strobe in memory tenure
        cyc(1,0,0,1,0, 1,3'b000, "R6 memory start");
        cyc(0,1,0,1,0, 0,3'b100, "R6 ext in open");
        cyc(0,0,1,0,0, 0,3'b000, "R6 ack");
        cyc(0,1,0,0,0, 0,3'b100, "R6 ext in tail");
        cyc(0,0,0,0,0, 0,3'b000, "R6 idle");
        // R7 direct-store tenure
        cyc(0,1,0,1,0, 0,3'b000, "R7 ext legal start");
        cyc(0,0,0,1,0, 0,3'b000, "R7 open");
        cyc(0,1,0,1,0, 0,3'b001, "R7 ext in ds window");
        cyc(1,0,1,0,0, 0,3'b001, "R7 start in ds window");
        cyc(0,0,0,0,0, 0,3'b000, "R7 tail");
        // R8 both strobes together
        cyc(1,1,0,0,0, 0,3'b001, "R8 both strobes");
        cyc(0,0,0,0,0, 0,3'b000, "R8 idle");
        cyc(1,0,0,0,0, 1,3'b000, "R8 no window opened");
        cyc(0,0,1,0,0, 0,3'b000, "R8 ack");
        cyc(0,0,0,0,0, 0,3'b000, "R8 tail");
        // R9 clear, and event beats clear
        cyc(0,0,0,0,1, 0,3'b000, "R9 clear flags");
        cyc(1,1,0,0,1, 0,3'b001, "R9 event wins over clear");
        cyc(0,0,0,0,0, 0,3'b000, "R9 flag holds");
        // R11 acknowledge in the start cycle
        cyc(1,0,1,0,0, 1,3'b000, "R11 start with ack");
        cyc(0,0,0,0,0, 0,3'b000, "R11 tail");
        cyc(1,0,0,0,0, 1,3'b000, "R11 legal after short window");
        cyc(0,0,1,0,0, 0,3'b000, "R11 ack");
        cyc(0,0,0,0,0, 0,3'b000, "R11 tail2");
        // R5 held extended strobe
        cyc(0,1,0,1,0, 0,3'b000, "R5 ext legal start");
        cyc(0,1,0,1,0, 0,3'b010, "R5 held ext");
        cyc(0,0,1,0,0, 0,3'b000, "R5 ext ack");
        cyc(0,0,0,0,0, 0,3'b000, "R5 ext tail");

        @(negedge clk);
        // R10: reset clears sticky flags
        rst_n = 1'b0; start_i = 1'b1;
        repeat (2) @(negedge clk);
        check_quiet("R10 reset clears flags");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule